// File: doc/BRIEF.md
# Parallel LCD Sync Timing Generator

This block produces the line sync, frame sync and data-valid timing for a 320x240 TFT panel that is fed one byte at a time over an 8-bit parallel port. A pixel therefore spans several port clocks: two in 16-bit colour mode and three in 24-bit colour mode. Every horizontal interval is expressed in pixel times and scaled by that factor. The start of the active window is also pushed later by a fixed latency that depends on the mode. This latency stands for the external pixel pipeline between the port and the panel.

The generator runs one horizontal counter over port clocks and one line counter over lines. It decodes both counters into registered outputs: active-low HS and VS, a data-enable strobe, the current pixel index, the byte phase within that pixel, the active line index, and a one-clock start-of-frame pulse. A downstream fetch engine uses the start-of-frame pulse to begin reading a new frame. The colour mode is chosen at elaboration. Raising the enable input starts both counters together from the origin of a frame. Lowering it parks the outputs in their idle state.

Top module: `lcd_sync_gen`

## Requirements
- R1: Outputs are registered. On the first clock edge that samples `en` high, the outputs take the values of frame position 0, and `sof` is high in the following cycle.
- R2: `hs_n` is low for the first 2*CPP port clocks of every line, and a line lasts 336*CPP port clocks. CPP is the number of clocks per pixel.
- R3: `vs_n` is low for VS_WIDTH_CLKS port clocks counted from the first clock of each frame, and this window may cross line boundaries. The default width is 2*CPP. A frame lasts (240+4) lines.
- R4: `de` is high from clock 7*CPP+D to clock 7*CPP+D+320*CPP-1 of each line, counted within the line, where D is the pipeline delay. It is high only on lines 2 to 241 of the frame, which leaves two blanking lines at the top and two at the bottom.
- R5: While `de` is high, `pix_x` gives the pixel index (0 to 319) and `phase` gives the byte index within that pixel (0 to CPP-1). Both are 0 while `de` is low.
- R6: While `de` is high, `line_y` gives the active line index, which is the frame line minus 2. It is 0 while `de` is low.
- R7: `sof` is high for exactly one clock, at frame position 0 of every frame. The line counter wraps back to line 0 after the last blanking line.
- R8: While `rst` is high, and in the cycle after any edge that samples `en` low, `hs_n` and `vs_n` are 1 and `de`, `sof`, `pix_x`, `phase` and `line_y` are 0. Lowering `en` restarts the next run at frame position 0.
- R9: In 16-bit mode (MODE=0) CPP is 2 and D is 3. In 24-bit mode (MODE=1) CPP is 3 and D is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; counters start from zero when it rises |
| hs_n | output | 1 | Line sync, active low |
| vs_n | output | 1 | Frame sync, active low |
| de | output | 1 | Active-window strobe |
| sof | output | 1 | One-clock start-of-frame pulse |
| pix_x | output | XW | Pixel index in the active line |
| line_y | output | YW | Active line index |
| phase | output | 2 | Byte index within the current pixel |

## Verification
The start-of-frame pulse, the start of the HS pulse and the start of the VS pulse all fall in the same clock at frame position 0. In the 24-bit configuration the VS pulse is widened past one line, so the VS pulse is still low when the HS pulse of the second line begins. Enable is dropped partway through a frame and reset is pulsed while running, so that this shared cycle is hit again from a fresh start rather than only at the natural wrap. A scoreboard computes every output from the elapsed clock count, so a misplaced coincidence, a missed wrap or a lost restart shows up as a mismatch in the exact cycle where it happens.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic {
    MODE_RGB16 = 1'b0,
    MODE_RGB24 = 1'b1
  } lcd_mode_e;

  // port clocks spent on one pixel
  function automatic int clks_per_pix(lcd_mode_e m);
    return (m == MODE_RGB24) ? 3 : 2;
  endfunction

  // latency of the external pixel pipeline, in port clocks
  function automatic int pipe_delay(lcd_mode_e m);
    return (m == MODE_RGB24) ? 5 : 3;
  endfunction

endpackage

// File: rtl/lcd_sync_hcount.sv
module lcd_sync_hcount #(
  parameter int HP      = 672,
  parameter int H_START = 17,
  parameter int H_END   = 657,
  parameter int CPP     = 2,
  parameter int HW      = 10,
  parameter int XW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic [XW-1:0] pcnt,
  output logic [1:0]    pph
);

  logic in_win;

  assign line_end = en && (hcnt == HW'(HP - 1));
  assign in_win   = (hcnt >= HW'(H_START)) && (hcnt < HW'(H_END));

  // clock position inside the line
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt <= '0;
    end else if (hcnt == HW'(HP - 1)) begin
      hcnt <= '0;
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  // pixel index and byte phase, kept in step with hcnt through the window
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pcnt <= '0;
      pph  <= '0;
    end else if (hcnt == HW'(H_START - 1)) begin
      pcnt <= '0;
      pph  <= '0;
    end else if (in_win) begin
      if (pph == 2'(CPP - 1)) begin
        pph  <= '0;
        pcnt <= pcnt + XW'(1);
      end else begin
        pph  <= pph + 2'd1;
      end
    end
  end

endmodule

// File: rtl/lcd_sync_vcount.sv
module lcd_sync_vcount #(
  parameter int V_TOT = 244,
  parameter int VW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          line_end,
  output logic [VW-1:0] vcnt
);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      vcnt <= '0;
    end else if (line_end) begin
      if (vcnt == VW'(V_TOT - 1)) begin
        vcnt <= '0;
      end else begin
        vcnt <= vcnt + VW'(1);
      end
    end
  end

endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode #(
  parameter int HP      = 672,
  parameter int HSW     = 4,
  parameter int VSW     = 4,
  parameter int H_START = 17,
  parameter int H_END   = 657,
  parameter int V_TOP   = 2,
  parameter int V_ACT   = 240,
  parameter int HW      = 10,
  parameter int VW      = 8,
  parameter int XW      = 9,
  parameter int YW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic [XW-1:0] pcnt,
  input  logic [1:0]    pph,
  output logic          hs_n,
  output logic          vs_n,
  output logic          de,
  output logic          sof,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] line_y,
  output logic [1:0]    phase
);

  localparam int VS_LINES = VSW / HP;
  localparam int VS_REM   = VSW % HP;

  logic hs_c, vs_c, de_c, sof_c, line_act, h_win;

  assign hs_c     = en && (hcnt < HW'(HSW));
  assign line_act = (vcnt >= VW'(V_TOP)) && (vcnt < VW'(V_TOP + V_ACT));
  assign h_win    = (hcnt >= HW'(H_START)) && (hcnt < HW'(H_END));
  assign de_c     = en && line_act && h_win;
  assign sof_c    = en && (hcnt == '0) && (vcnt == '0);

  // frame sync: a short pulse needs only the first line, a long one spans lines
  generate
    if (VS_LINES == 0) begin : g_vs_short
      assign vs_c = en && (vcnt == '0) && (hcnt < HW'(VS_REM));
    end else begin : g_vs_long
      assign vs_c = en && ((vcnt < VW'(VS_LINES)) ||
                           ((vcnt == VW'(VS_LINES)) && (hcnt < HW'(VS_REM))));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_n   <= 1'b1;
      vs_n   <= 1'b1;
      de     <= 1'b0;
      sof    <= 1'b0;
      pix_x  <= '0;
      line_y <= '0;
      phase  <= '0;
    end else begin
      hs_n   <= ~hs_c;
      vs_n   <= ~vs_c;
      de     <= de_c;
      sof    <= sof_c;
      pix_x  <= de_c ? pcnt : '0;
      line_y <= de_c ? YW'(vcnt - VW'(V_TOP)) : '0;
      phase  <= de_c ? pph : '0;
    end
  end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter lcd_mode_e MODE          = MODE_RGB16,
  parameter int        H_ACT_PIX     = 320,
  parameter int        H_TOTAL_PIX   = 336,
  parameter int        H_SYNC_PIX    = 2,
  parameter int        H_LEAD_PIX    = 7,
  parameter int        V_ACT_LINES   = 240,
  parameter int        V_BLANK_LINES = 4,
  parameter int        V_TOP_LINES   = 2,
  parameter int        VS_WIDTH_CLKS = 2 * clks_per_pix(MODE),
  localparam int       XW = (H_ACT_PIX > 1) ? $clog2(H_ACT_PIX) : 1,
  localparam int       YW = (V_ACT_LINES > 1) ? $clog2(V_ACT_LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          hs_n,
  output logic          vs_n,
  output logic          de,
  output logic          sof,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] line_y,
  output logic [1:0]    phase
);

  localparam int CPP     = clks_per_pix(MODE);
  localparam int HP      = H_TOTAL_PIX * CPP;
  localparam int HSW     = H_SYNC_PIX * CPP;
  localparam int H_START = H_LEAD_PIX * CPP + pipe_delay(MODE);
  localparam int H_END   = H_START + H_ACT_PIX * CPP;
  localparam int V_TOT   = V_ACT_LINES + V_BLANK_LINES;
  localparam int HW      = $clog2(HP + 1);
  localparam int VW      = $clog2(V_TOT + 1);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [XW-1:0] pcnt;
  logic [1:0]    pph;
  logic          line_end;

  lcd_sync_hcount #(
    .HP(HP), .H_START(H_START), .H_END(H_END), .CPP(CPP), .HW(HW), .XW(XW)
  ) u_hcount (
    .clk(clk), .rst(rst), .en(en),
    .hcnt(hcnt), .line_end(line_end), .pcnt(pcnt), .pph(pph)
  );

  lcd_sync_vcount #(
    .V_TOT(V_TOT), .VW(VW)
  ) u_vcount (
    .clk(clk), .rst(rst), .en(en), .line_end(line_end), .vcnt(vcnt)
  );

  lcd_sync_decode #(
    .HP(HP), .HSW(HSW), .VSW(VS_WIDTH_CLKS), .H_START(H_START), .H_END(H_END),
    .V_TOP(V_TOP_LINES), .V_ACT(V_ACT_LINES),
    .HW(HW), .VW(VW), .XW(XW), .YW(YW)
  ) u_decode (
    .clk(clk), .rst(rst), .en(en),
    .hcnt(hcnt), .vcnt(vcnt), .pcnt(pcnt), .pph(pph),
    .hs_n(hs_n), .vs_n(vs_n), .de(de), .sof(sof),
    .pix_x(pix_x), .line_y(line_y), .phase(phase)
  );

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int CPP = 2,
  parameter int XW  = 9,
  parameter int YW  = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          hs_n,
  input logic          vs_n,
  input logic          de,
  input logic          sof,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] line_y,
  input logic [1:0]    phase
);

  // R1: a rising enable lands on the frame origin
  a_r1_start_at_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> sof);

  // R8: enable low parks every output
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hs_n && vs_n && !de && !sof && pix_x == '0 && line_y == '0 && phase == '0));

  // R7: the frame origin coincides with both sync pulses
  a_r7_sof_with_syncs: assert property (@(posedge clk) disable iff (rst)
    sof |-> (!hs_n && !vs_n));

  // R4: the active window never overlaps the line sync
  a_r4_de_outside_hs: assert property (@(posedge clk) disable iff (rst)
    de |-> hs_n);

  // R5: byte phase stays inside one pixel
  a_r5_phase_range: assert property (@(posedge clk) disable iff (rst)
    de |-> (phase < 2'(CPP)));

  // R5: a new pixel inside the window advances the index by one
  a_r5_pix_step: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de) && phase == '0) |-> (pix_x == XW'($past(pix_x) + XW'(1))));

  // R6: line index is constant across a line's window
  a_r6_line_steady: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de)) |-> (line_y == $past(line_y)));

  // R7: start-of-frame lasts a single clock
  a_r7_sof_single: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);

endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.CPP(CPP), .XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .hs_n(hs_n), .vs_n(vs_n), .de(de),
  .sof(sof), .pix_x(pix_x), .line_y(line_y), .phase(phase)
);

// File: tb/lcd_sync_gen_bench.sv
module lcd_sync_gen_bench;
  import lcd_sync_pkg::*;

  // reduced geometry so several frames fit in a short run
  localparam int G_HACT = 6, G_HTOT = 12, G_HSYNC = 2, G_HLEAD = 2;
  localparam int G_VACT = 3, G_VBLANK = 2, G_VTOP = 1;
  localparam int W_VSW  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #4 clk = ~clk;

  logic       n_hs, n_vs, n_de, n_sof, w_hs, w_vs, w_de, w_sof;
  logic [2:0] n_pix, w_pix;
  logic [1:0] n_line, w_line, n_ph, w_ph;

  lcd_sync_gen #(
    .MODE(MODE_RGB16), .H_ACT_PIX(G_HACT), .H_TOTAL_PIX(G_HTOT), .H_SYNC_PIX(G_HSYNC),
    .H_LEAD_PIX(G_HLEAD), .V_ACT_LINES(G_VACT), .V_BLANK_LINES(G_VBLANK),
    .V_TOP_LINES(G_VTOP)
  ) u_lcd_sync_gen (
    .clk(clk), .rst(rst), .en(en), .hs_n(n_hs), .vs_n(n_vs), .de(n_de), .sof(n_sof),
    .pix_x(n_pix), .line_y(n_line), .phase(n_ph)
  );

  lcd_sync_gen #(
    .MODE(MODE_RGB24), .H_ACT_PIX(G_HACT), .H_TOTAL_PIX(G_HTOT), .H_SYNC_PIX(G_HSYNC),
    .H_LEAD_PIX(G_HLEAD), .V_ACT_LINES(G_VACT), .V_BLANK_LINES(G_VBLANK),
    .V_TOP_LINES(G_VTOP), .VS_WIDTH_CLKS(W_VSW)
  ) u_lcd_sync_gen_wide (
    .clk(clk), .rst(rst), .en(en), .hs_n(w_hs), .vs_n(w_vs), .de(w_de), .sof(w_sof),
    .pix_x(w_pix), .line_y(w_line), .phase(w_ph)
  );

  typedef struct {
    bit   idle;
    logic hs_n, vs_n, de, sof;
    int   pix, line, ph;
  } exp_t;

  typedef struct {
    exp_t n;
    exp_t w;
  } pair_t;

  pair_t sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  int    pos    = 0;
  bit    done   = 0;

  function automatic exp_t idle_exp();
    exp_t e;
    e.idle = 1; e.hs_n = 1; e.vs_n = 1; e.de = 0; e.sof = 0;
    e.pix = 0; e.line = 0; e.ph = 0;
    return e;
  endfunction

  // expected outputs at clock k of a run, from the requirement formulas
  function automatic exp_t model(int k, int cpp, int dly, int vsw);
    exp_t e;
    int hp, vt, h, v, f, hs0, he;
    hp  = G_HTOT * cpp;
    vt  = G_VACT + G_VBLANK;
    h   = k % hp;
    v   = (k / hp) % vt;
    f   = k % (hp * vt);
    hs0 = G_HLEAD * cpp + dly;
    he  = hs0 + G_HACT * cpp;
    e.idle = 0;
    e.hs_n = !(h < G_HSYNC * cpp);
    e.vs_n = !(f < vsw);
    e.sof  = (f == 0);
    e.de   = (v >= G_VTOP) && (v < G_VTOP + G_VACT) && (h >= hs0) && (h < he);
    e.pix  = e.de ? (h - hs0) / cpp : 0;
    e.ph   = e.de ? (h - hs0) % cpp : 0;
    e.line = e.de ? v - G_VTOP : 0;
    return e;
  endfunction

  task automatic step(bit r, bit e, int n);
    pair_t p;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = r;
      en  = e;
      if (r || !e) begin
        p.n = idle_exp();
        p.w = idle_exp();
        pos = 0;
      end else begin
        p.n = model(pos, 2, 3, 2 * 2);
        p.w = model(pos, 3, 5, W_VSW);
        pos++;
      end
      sb_q.push_back(p);
    end
  endtask

  function automatic string tg(bit idle, bit wide, string base);
    if (idle) return "R8";
    return wide ? {"R9 ", base} : base;
  endfunction

  task automatic cmp(string tag, string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, fld, $time, act, exp);
    end
  endtask

  // monitor: pop one expectation per edge and compare both instances
  initial begin
    pair_t p;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        p = sb_q.pop_front();
        cmp(tg(p.n.idle, 0, "R2"), "hs_n", int'(n_hs), int'(p.n.hs_n));
        cmp(tg(p.n.idle, 0, "R3"), "vs_n", int'(n_vs), int'(p.n.vs_n));
        cmp(tg(p.n.idle, 0, "R4"), "de", int'(n_de), int'(p.n.de));
        cmp(tg(p.n.idle, 0, "R1/R7"), "sof", int'(n_sof), int'(p.n.sof));
        cmp(tg(p.n.idle, 0, "R5"), "pix_x", int'(n_pix), p.n.pix);
        cmp(tg(p.n.idle, 0, "R5"), "phase", int'(n_ph), p.n.ph);
        cmp(tg(p.n.idle, 0, "R6"), "line_y", int'(n_line), p.n.line);
        cmp(tg(p.w.idle, 1, "R2"), "hs_n", int'(w_hs), int'(p.w.hs_n));
        cmp(tg(p.w.idle, 1, "R3"), "vs_n", int'(w_vs), int'(p.w.vs_n));
        cmp(tg(p.w.idle, 1, "R4"), "de", int'(w_de), int'(p.w.de));
        cmp(tg(p.w.idle, 1, "R1/R7"), "sof", int'(w_sof), int'(p.w.sof));
        cmp(tg(p.w.idle, 1, "R5"), "pix_x", int'(w_pix), p.w.pix);
        cmp(tg(p.w.idle, 1, "R5"), "phase", int'(w_ph), p.w.ph);
        cmp(tg(p.w.idle, 1, "R6"), "line_y", int'(w_line), p.w.line);
      end
    end
  end

  // driver
  initial begin
    step(1, 0, 3);     // R8 reset state
    step(0, 0, 4);     // R8 enable low
    step(0, 1, 400);   // R1 start, several frames: R2 R3 R4 R5 R6 R7 R9
    step(0, 0, 3);     // R8 enable dropped mid-frame
    step(0, 1, 250);   // R1 restart from origin
    step(1, 1, 2);     // reset while running
    step(0, 1, 200);
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule